// File: doc/BRIEF.md
# Rollover-Safe Clock Register Reader

This block sits on the host side of a serial link to a real-time clock. It collects the seven timekeeping registers with one single-register read each. A seconds carry can ripple through the other counters while the host is partway through. To guard against this, the block samples seconds once before the other six registers and once after them. It accepts the collected set only when the two seconds samples agree. If they differ, the whole pass is discarded and started again from seconds.

The block does not drive bit-level serial timing. It hands one command byte at a time to a byte-level transaction engine and waits for that engine's done strobe, which carries the response byte. A one-cycle start pulse launches a read. A one-cycle valid pulse delivers a consistent set of seven values. A retry counter shows how many passes were thrown away. If too many passes fail, an error flag ends the attempt. The block does not decode the register contents.

Top module: `rtc_snapshot_reader`

## Requirements
- R1: After reset, busy, xfer_req, time_valid and retry_err are low, and retry_cnt and time_out are zero.
- R2: A start pulse seen while idle raises busy at the next clock edge. It also clears retry_cnt and retry_err. From the next cycle on, the first command requests seconds.
- R3: A command byte has bit 7 set (read) and holds BASE_ADDR plus the register index in bits 6:0. The indices are seconds 0, minutes 1, hours 2, date 3, month 4, weekday 5 and year 6. One pass issues eight reads in the order seconds, minutes, hours, date, month, weekday, year, seconds.
- R4: xfer_req is high exactly while busy. xfer_cmd holds steady until xfer_done. The next command appears in the cycle after xfer_done. An xfer_done while xfer_req is low has no effect.
- R5: When the eighth response equals the first seconds sample, the cycle after that response shows time_valid high for one cycle with busy low. In that same cycle time_out carries the pass's values, with register index k in bits 8k+7:8k.
- R6: When the eighth response differs from the first seconds sample, the pass is discarded and retry_cnt rises by one. time_out keeps its value, and the next cycle issues a seconds command again.
- R7: When a discarded pass brings retry_cnt to MAX_RETRY, the block returns to idle with retry_err high and gives no valid pulse. retry_err stays high until the next accepted start.
- R8: A start pulse that arrives while busy, including one in the cycle of the eighth response, has no effect on the running pass and does not launch another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a consistent read |
| xfer_req | output | 1 | Command byte is waiting for the transaction engine |
| xfer_cmd | output | 8 | Command byte: read flag and register address |
| xfer_done | input | 1 | Transaction finished, response valid |
| xfer_rdata | input | 8 | Response byte |
| busy | output | 1 | A read sequence is running |
| time_valid | output | 1 | One-cycle pulse: time_out is a consistent set |
| time_out | output | 56 | Seven register values, index k in bits 8k+7:8k |
| retry_cnt | output | CNT_W | Passes discarded since the last accepted start |
| retry_err | output | 1 | Retry limit reached, attempt abandoned |

## Verification
Two events can fall in the same cycle. The eighth response can arrive together with a fresh start pulse. A seconds increment can land right after one chosen read of a pass. The transaction model in the bench raises start in exactly the cycle it returns the closing seconds byte, and it bumps the seconds counter after a chosen read: after the opening sample, to force a retry, or after the closing sample, where it must be harmless. The behavioural model in the bench predicts whether each pass is accepted or discarded, and it flags any extra pass launched by the coinciding start.

// File: rtl/rtc_snapshot_reader.sv
module rtc_snapshot_reader #(
  parameter int BASE_ADDR = 1,
  parameter int MAX_RETRY = 4,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             xfer_req,
  output logic [7:0]       xfer_cmd,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rdata,
  output logic             busy,
  output logic             time_valid,
  output logic [55:0]      time_out,
  output logic [CNT_W-1:0] retry_cnt,
  output logic             retry_err
);
  localparam logic [2:0] LAST_STEP = 3'd7;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]       step;
  logic [7:0]       shadow [7];
  logic [2:0]       reg_idx;
  logic             take, final_rd, match, give_up;
  logic [CNT_W-1:0] retry_next;

  assign reg_idx    = (step == LAST_STEP) ? 3'd0 : step;
  assign xfer_req   = busy;
  assign xfer_cmd   = {1'b1, 7'(BASE_ADDR) + {4'b0, reg_idx}};
  assign take       = busy && xfer_done;
  assign final_rd   = take && (step == LAST_STEP);
  assign match      = (xfer_rdata == shadow[0]);
  assign retry_next = (retry_cnt == CNT_MAX) ? retry_cnt : retry_cnt + 1'b1;
  assign give_up    = final_rd && !match && (32'(retry_next) >= MAX_RETRY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      step       <= 3'd0;
      time_valid <= 1'b0;
      time_out   <= '0;
      retry_cnt  <= '0;
      retry_err  <= 1'b0;
    end else begin
      time_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          step      <= 3'd0;
          retry_cnt <= '0;
          retry_err <= 1'b0;
        end
      end else if (take) begin
        if (!final_rd) begin
          step <= step + 3'd1;
        end else if (match) begin
          busy       <= 1'b0;
          time_valid <= 1'b1;
          time_out   <= {shadow[6], shadow[5], shadow[4], shadow[3],
                         shadow[2], shadow[1], shadow[0]};
        end else begin
          retry_cnt <= retry_next;
          step      <= 3'd0;
          if (give_up) begin
            busy      <= 1'b0;
            retry_err <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) shadow[i] <= 8'h00;
    end else if (take && !final_rd) begin
      shadow[step] <= xfer_rdata;
    end
  end

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_cmd));

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |=> !time_valid);

  assert_valid_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    time_valid |-> !busy && $past(xfer_done));

  assert_retry_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> retry_cnt >= $past(retry_cnt));

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_err |-> !busy && !time_valid);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !xfer_done |=> busy && $stable(retry_cnt));
endmodule

// File: tb/rtc_snapshot_reader_tb.sv
module rtc_snapshot_reader_tb_top;
  localparam int BASE = 1;
  localparam int MAXR = 4;
  localparam int CW   = 3;

  logic clk = 1'b0, rst_n = 1'b0, start_a = 1'b0, start_b = 1'b0;
  logic done = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic start;
  logic req, busy, valid, err;
  logic [7:0] cmd;
  logic [55:0] tout;
  logic [CW-1:0] rcnt;

  assign start = start_a | start_b;
  always #2 clk = ~clk;

  rtc_snapshot_reader #(.BASE_ADDR(BASE), .MAX_RETRY(MAXR), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_req(req), .xfer_cmd(cmd),
    .xfer_done(done), .xfer_rdata(rdata), .busy(busy), .time_valid(valid),
    .time_out(tout), .retry_cnt(rcnt), .retry_err(err));

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] rtc [7];
  int serve_n = 0, bump_idx = -1, bump_left = 0, lat = 0, wait_cnt = 0;
  bit fire_last = 0, stray = 0;
  int valid_seen = 0;

  bit m_busy = 0, m_valid = 0, m_err = 0;
  int m_step = 0, m_retry = 0;
  logic [7:0] m_sh [7];
  logic [7:0] m_time [7];

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic logic [55:0] pack_model();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[8*k +: 8] = m_time[k];
    return v;
  endfunction

  function automatic logic [55:0] pack_rtc();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[8*k +: 8] = rtc[k];
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_err = 0; m_step = 0; m_retry = 0;
      for (int k = 0; k < 7; k++) begin m_sh[k] = 8'h00; m_time[k] = 8'h00; end
    end else begin
      m_valid = 0;
      if (!m_busy) begin
        if (start) begin m_busy = 1; m_step = 0; m_retry = 0; m_err = 0; end
      end else if (done) begin
        if (m_step < 7) begin
          m_sh[m_step] = rdata;
          m_step++;
        end else if (rdata == m_sh[0]) begin
          for (int k = 0; k < 7; k++) m_time[k] = m_sh[k];
          m_valid = 1; m_busy = 0;
        end else begin
          if (m_retry < (1 << CW) - 1) m_retry++;
          m_step = 0;
          if (m_retry >= MAXR) begin m_err = 1; m_busy = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4", "xfer_req", req, m_busy);
      chk("R2", "busy", busy, m_busy);
      if (m_busy) chk("R3", "xfer_cmd", cmd, 8'h80 | 8'(BASE + (m_step == 7 ? 0 : m_step)));
      chk("R5", "time_valid", valid, m_valid);
      chk("R5", "time_out", tout, pack_model());
      chk("R6", "retry_cnt", rcnt, m_retry);
      chk("R7", "retry_err", err, m_err);
      if (valid) valid_seen++;
    end
    if (done) begin
      done = 0; wait_cnt = 0; start_b = 0;
    end else if (stray && !req) begin
      stray = 0; done = 1; rdata = 8'hEE;
    end else if (req) begin
      if (wait_cnt >= lat) begin
        int pidx;
        rdata = rtc[int'(cmd[6:0]) - BASE];
        done = 1;
        pidx = serve_n % 8;
        serve_n++;
        if (pidx == bump_idx && bump_left > 0) begin rtc[0] = rtc[0] + 8'd1; bump_left--; end
        if (pidx == 7 && fire_last) begin start_b = 1; fire_last = 0; end
      end else wait_cnt++;
    end
  end

  task automatic run_read;
    @(negedge clk); serve_n = 0; start_a = 1;
    @(negedge clk); start_a = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [55:0] snap;
    rtc[0] = 8'h10; rtc[1] = 8'h21; rtc[2] = 8'h32; rtc[3] = 8'h43;
    rtc[4] = 8'h54; rtc[5] = 8'h65; rtc[6] = 8'h76;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset req", req, 0);
    chk("R1", "reset valid", valid, 0);
    chk("R1", "reset err", err, 0);
    chk("R1", "reset retry", rcnt, 0);
    chk("R1", "reset time_out", tout, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R5 clean pass, zero latency
    lat = 0; valid_seen = 0;
    run_read();
    chk("R5", "clean pass value", tout, pack_rtc());
    chk("R5", "clean pass valid count", valid_seen, 1);

    // R6 one rollover after the opening seconds sample
    lat = 2; bump_idx = 0; bump_left = 1; valid_seen = 0;
    run_read();
    chk("R6", "one retry", rcnt, 1);
    chk("R6", "fresh seconds", tout, pack_rtc());

    // R3 rollover after the closing sample is harmless
    bump_idx = 7; bump_left = 1;
    snap = pack_rtc();
    run_read();
    chk("R3", "late bump no retry", rcnt, 0);
    chk("R3", "late bump value", tout, snap);

    // R7 persistent rollover exhausts retries
    bump_idx = 3; bump_left = 100; valid_seen = 0;
    snap = tout;
    run_read();
    chk("R7", "error flag", err, 1);
    chk("R7", "retry limit", rcnt, MAXR);
    chk("R7", "no valid", valid_seen, 0);
    chk("R7", "time_out held", tout, snap);
    bump_left = 0;

    // R4 stray done while idle
    stray = 1;
    repeat (4) @(negedge clk);
    chk("R4", "stray done busy", busy, 0);
    chk("R4", "stray done time_out", tout, snap);

    // R8 start mid-pass and start together with the closing response
    lat = 1; valid_seen = 0; fire_last = 1;
    @(negedge clk); serve_n = 0; start_a = 1;
    @(negedge clk); start_a = 0;
    repeat (5) @(negedge clk);
    start_a = 1;
    @(negedge clk); start_a = 0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R8", "no relaunch", busy, 0);
    chk("R8", "single valid", valid_seen, 1);
    chk("R7", "error cleared by start", err, 0);
    chk("R8", "value", tout, pack_rtc());

    report();
  end
endmodule